// File: doc/BRIEF.md
# Watchdog Event Classifier and Reset Pulser

This block watches the active-low watchdog line driven by the application processor and decides whether each falling edge is a real processor watchdog reset. Edges that follow from the system reset already being held low, or from the power-management IC (PMIC) having dropped its power-good, are not real watchdog resets and are discarded. Classification is only armed while an external enable is high. The power sequencer clears this enable just before shutting the processor down and sets it again just after start-up.

A real watchdog event, or a one-cycle warm-reset request strobe, starts one active-low system reset pulse. The pulse lasts a fixed number of millisecond ticks. A two-bit cause code records which of the two started the most recent pulse. The raw watchdog level is also passed straight through to the PMIC.

Top module: `wdt_reset_pulser`

## Requirements
- R1: `pmic_wdt_n` equals `wdt_n_in` at all times, with no register in the path.
- R2: A falling edge of `wdt_n_in` is treated as a real watchdog event when `irq_en`, `pgood` and `sys_rst_lvl` are all high. A real event drives `sys_rst_n` low on the third rising clock edge after the edge is sampled (two synchronizer flops, then the edge register). It also sets `cause` to 2'b01.
- R3: A falling edge seen while `sys_rst_lvl` is low has no effect on `sys_rst_n` or `cause`.
- R4: A falling edge seen while `pgood` is low has no effect on `sys_rst_n` or `cause`.
- R5: A falling edge seen while `irq_en` is low has no effect on `sys_rst_n` or `cause`.
- R6: A `warm_req` pulse while no reset pulse is running drives `sys_rst_n` low on the next clock edge and sets `cause` to 2'b10.
- R7: Once started, `sys_rst_n` stays low through exactly `PULSE_MS` clock cycles with `ms_tick` high. It is released on the edge that samples the `PULSE_MS`-th tick. A tick in the start cycle is not counted.
- R8: A warm-reset request or watchdog edge that arrives while a pulse is running is ignored. It neither extends the pulse nor changes `cause`.
- R9: After reset, `sys_rst_n` is 1 and `cause` is 2'b00. The synchronizer starts at the idle (high) level, so releasing reset with the line high produces no event.
- R10: When a real watchdog event and `warm_req` fall in the same cycle, a single pulse starts and `cause` is 2'b01.
- R11: A rising edge of `wdt_n_in` starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| wdt_n_in | input | 1 | Processor watchdog line, active low, asynchronous |
| pgood | input | 1 | PMIC power-good |
| sys_rst_lvl | input | 1 | Observed level of the system reset net |
| warm_req | input | 1 | Warm-reset request strobe |
| irq_en | input | 1 | Arms watchdog classification |
| pmic_wdt_n | output | 1 | Watchdog level forwarded to the PMIC |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| cause | output | 2 | Cause of the last pulse: 01 watchdog, 10 warm request |

## Verification
The bench walks a table of watchdog falls under each gating condition. A design that dropped any one gate would pulse the reset when it should not, or would overwrite the cause code. Pulse length is checked one tick short of the end and again on the final tick, so an off-by-one counter shows up as an early or late release. The bench also sends a request and a watchdog fall into a running pulse; a design that restarted its counter would still be low when the original pulse should have ended. A watchdog fall and a request in the same cycle must give cause 01 and a single pulse. A rising watchdog edge must not start a pulse.

// File: rtl/wdt_reset_pulser.sv
module wdt_reset_pulser #(
  parameter int PULSE_MS    = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       wdt_n_in,
  input  logic       pgood,
  input  logic       sys_rst_lvl,
  input  logic       warm_req,
  input  logic       irq_en,
  output logic       pmic_wdt_n,
  output logic       sys_rst_n,
  output logic [1:0] cause
);
  localparam int CW = $clog2(PULSE_MS + 1);
  localparam logic [1:0] CAUSE_WDT  = 2'b01;
  localparam logic [1:0] CAUSE_WARM = 2'b10;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   active_q;
  logic [CW-1:0]          cnt_q;
  logic                   wdt_s, wdt_hit;

  assign pmic_wdt_n = wdt_n_in;
  assign wdt_s      = sync_q[SYNC_STAGES-1];
  assign wdt_hit    = irq_en & pgood & sys_rst_lvl & prev_q & ~wdt_s;
  assign sys_rst_n  = ~active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '1;
      prev_q   <= 1'b1;
      active_q <= 1'b0;
      cnt_q    <= '0;
      cause    <= 2'b00;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], wdt_n_in};
      prev_q <= wdt_s;
      if (!active_q) begin
        if (wdt_hit || warm_req) begin
          active_q <= 1'b1;
          cnt_q    <= '0;
          cause    <= wdt_hit ? CAUSE_WDT : CAUSE_WARM;
        end
      end else if (ms_tick) begin
        if (cnt_q == CW'(PULSE_MS - 1)) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_reset_pulser_chk.sv
module wdt_reset_pulser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ms_tick,
  input logic       pgood,
  input logic       sys_rst_lvl,
  input logic       warm_req,
  input logic       irq_en,
  input logic       sys_rst_n,
  input logic [1:0] cause
);
  p_warm_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_req && sys_rst_n) |=> !sys_rst_n);

  p_hold_without_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst_n && !ms_tick) |=> !sys_rst_n);

  p_release_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(ms_tick));

  p_cause_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |=> $stable(cause));

  // Covers R3, R4 and R5: a pulse not started by a request needs all gates open.
  p_wdt_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sys_rst_n) && !$past(warm_req)) |-> ($past(pgood) && $past(irq_en) && $past(sys_rst_lvl)));

  p_cause_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cause) |-> $fell(sys_rst_n));
endmodule

bind wdt_reset_pulser wdt_reset_pulser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pgood(pgood),
  .sys_rst_lvl(sys_rst_lvl), .warm_req(warm_req), .irq_en(irq_en),
  .sys_rst_n(sys_rst_n), .cause(cause)
);

// File: tb/sim_wdt_reset_pulser.sv
module sim_wdt_reset_pulser;
  localparam int PULSE_MS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ms_tick = 1'b0, wdt_n_in = 1'b1, pgood = 1'b1, warm_req = 1'b0, irq_en = 1'b1;
  logic ext_ok = 1'b1;
  logic sys_rst_lvl, pmic_wdt_n, sys_rst_n;
  logic [1:0] cause;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [1:0] exp_cause = 2'b00;

  always #2 clk = ~clk;
  assign sys_rst_lvl = sys_rst_n & ext_ok;

  wdt_reset_pulser #(.PULSE_MS(PULSE_MS)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wdt_n_in(wdt_n_in), .pgood(pgood),
    .sys_rst_lvl(sys_rst_lvl), .warm_req(warm_req), .irq_en(irq_en),
    .pmic_wdt_n(pmic_wdt_n), .sys_rst_n(sys_rst_n), .cause(cause));

  // {irq_en, pgood, ext_ok, expect_pulse}
  localparam logic [3:0] VEC [5] = '{4'b1111, 4'b1100, 4'b1010, 4'b0110, 4'b1111};

  function automatic string vtag(int i);
    case (i)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_clk(3);
    chk("R9", {31'd0, sys_rst_n}, 32'd1);
    chk("R9", {30'd0, cause}, 32'd0);
    rst_n = 1'b1;
    wait_clk(5);
    chk("R9", {31'd0, sys_rst_n}, 32'd1);

    wdt_n_in = 1'b0; #1;
    chk("R1", {31'd0, pmic_wdt_n}, 32'd0);
    wdt_n_in = 1'b1; #1;
    chk("R1", {31'd0, pmic_wdt_n}, 32'd1);
    wait_clk(4);

    for (int i = 0; i < 5; i++) begin
      irq_en = VEC[i][3]; pgood = VEC[i][2]; ext_ok = VEC[i][1];
      @(negedge clk) wdt_n_in = 1'b0;
      wait_clk(2);
      chk(vtag(i), {31'd0, sys_rst_n}, 32'd1);
      wait_clk(1);
      chk(vtag(i), {31'd0, sys_rst_n}, {31'd0, ~VEC[i][0]});
      if (VEC[i][0]) exp_cause = 2'b01;
      chk(vtag(i), {30'd0, cause}, {30'd0, exp_cause});
      if (VEC[i][0]) repeat (PULSE_MS) tick();
      irq_en = 1'b1; pgood = 1'b1; ext_ok = 1'b1;
      wdt_n_in = 1'b1;
      wait_clk(4);
      chk("R11", {31'd0, sys_rst_n}, 32'd1);
    end

    @(negedge clk) warm_req = 1'b1;
    @(negedge clk) warm_req = 1'b0;
    chk("R6", {31'd0, sys_rst_n}, 32'd0);
    chk("R6", {30'd0, cause}, 32'd2);
    repeat (PULSE_MS - 1) tick();
    chk("R7", {31'd0, sys_rst_n}, 32'd0);
    tick();
    chk("R7", {31'd1 & 31'd0, sys_rst_n}, 32'd1);

    @(negedge clk) warm_req = 1'b1;
    @(negedge clk) warm_req = 1'b0;
    tick(); tick();
    @(negedge clk) begin warm_req = 1'b1; wdt_n_in = 1'b0; end
    @(negedge clk) warm_req = 1'b0;
    wait_clk(4);
    repeat (PULSE_MS - 3) tick();
    chk("R8", {31'd0, sys_rst_n}, 32'd0);
    tick();
    chk("R8", {31'd0, sys_rst_n}, 32'd1);
    chk("R8", {30'd0, cause}, 32'd2);
    wdt_n_in = 1'b1;
    wait_clk(4);

    @(negedge clk) wdt_n_in = 1'b0;
    wait_clk(2);
    warm_req = 1'b1;
    @(negedge clk) warm_req = 1'b0;
    chk("R10", {31'd0, sys_rst_n}, 32'd0);
    chk("R10", {30'd0, cause}, 32'd1);
    repeat (PULSE_MS) tick();
    chk("R10", {31'd0, sys_rst_n}, 32'd1);
    wdt_n_in = 1'b1;
    wait_clk(4);

    rst_n = 1'b0;
    wait_clk(2);
    chk("R9", {30'd0, cause}, 32'd0);
    rst_n = 1'b1;
    wait_clk(5);
    chk("R9", {31'd0, sys_rst_n}, 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule